// File: doc/BRIEF.md
# Prioritised Interrupt Router

This block collects a set of external interrupt lines and routes them to a small number of target contexts, such as processor privilege levels or harts. Every source has a programmable priority. Every context has three things: its own enable bitmap over the sources, a priority threshold, and a single combined claim/complete register.

A context's interrupt-request output is high while at least one source meets three conditions: it is pending, it is enabled for that context, and its priority is strictly above that context's threshold. Software services a request in two steps. First it reads the claim register, which hands over the winning source ID and atomically takes that source out of the pending set. When the handler finishes, software writes the same ID back to the same register.

Each source passes through a gateway, configurable per source as level-high or rising-edge. The gateway forwards at most one request at a time and holds back the next one until the current one is completed. All registers sit behind a simple single-cycle request bus, where read data appears on the cycle after the request. The default instance has 32 source IDs (ID 0 is reserved, leaving 31 usable), 2 contexts and 3-bit priorities. The address map supports up to 1024 source IDs.

Top module: `irqc_top`

## Requirements
- R1: Source ID 0 is absent. Its priority reads 0 and ignores writes, its enable bit reads 0 in every context, and a claim read returns 0 when no source is eligible for that context.
- R2: The priority of source i is the word at byte offset 4*i. Only the low PRIO_W bits are stored; higher write bits are dropped and read back as 0.
- R3: The enable bitmap of context c begins at byte offset 0x2000 + 0x80*c. Source i is bit (i mod 32) of word (i / 32) in that region. A 1 enables the source for that context.
- R4: Context c's threshold is at 0x200000 + 0x1000*c, and its claim/complete register is at +4 from there. The per-source trigger mode is a bitmap at 0x1000, laid out like an enable bitmap, with 1 meaning rising-edge and 0 meaning level-high.
- R5: A source can interrupt a context only if its priority is strictly greater than the context's threshold. Priority 0 never interrupts, and a threshold of 7 blocks every source.
- R6: A claim read returns the eligible source with the highest priority, with the lowest ID winning ties. The read clears that source's pending state, so the next claim returns the next candidate.
- R7: Writing a claimed ID to the claim/complete register retires it, and only after that may its gateway forward a new request. A completion is ignored if the written ID is 0 or not below NSRC, or if the source is not enabled for the writing context.
- R8: In level mode, a source becomes pending while its line is high and its gateway is idle. After completion, a line that is still high makes the source pending again.
- R9: In edge mode, a rising edge is captured even if the line falls again before the claim. A rising edge seen while the source is in service is held and delivered after completion. A line held high with no new edge raises no further request.
- R10: The interrupt-request outputs are registered. A line that rises before clock edge k makes the source pending at edge k, and the request appears at edge k+1. A register write at edge k affects the request outputs at edge k+1.
- R11: The read data for a bus read request is presented on the cycle after the request and holds until the next read.
- R12: Contexts are independent. A source enabled only for context 1 raises only that context's output, and context 0's claim returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt lines; bit 0 is unused |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | NCTX | Interrupt request per context |

## Verification
Each result has a fixed due cycle. A line change is sampled on edge k and becomes pending there, and the request output follows at edge k+1. A register write at edge k is seen on the request outputs at edge k+1, and read data is valid right after the edge that took the read. A completion at edge k lets a level line re-pend at k+1, so a claim issued at k+2 sees it. The bench drives and samples on the falling edge and waits exactly those counts, and it checks the request outputs once one cycle early to confirm they are not combinational.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // Region bases of the byte address map
    localparam logic [31:0] BASE_TRIG = 32'h0000_1000;
    localparam logic [31:0] BASE_EN   = 32'h0000_2000;
    localparam logic [31:0] BASE_CTL  = 32'h0020_0000;
    localparam int          EN_SHIFT  = 7;   // 0x80 bytes per context
    localparam int          CTL_SHIFT = 12;  // 0x1000 bytes per context
    localparam logic [11:0] OFF_THR   = 12'h000;
    localparam logic [11:0] OFF_CLAIM = 12'h004;
endpackage

// File: rtl/irqc_gate.sv
module irqc_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic edge_mode,
    input  logic take,
    input  logic done,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic lat;
        logic pend;
        logic busy;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        logic rise;
        logic req;
        g_d  = g_q;
        rise = line & ~g_q.prev;
        g_d.prev = line;
        if (!edge_mode)
            g_d.lat = 1'b0;
        else if (rise)
            g_d.lat = 1'b1;
        req = edge_mode ? (g_q.lat | rise) : line;
        if (take) begin
            g_d.pend = 1'b0;
            g_d.busy = 1'b1;
        end
        if (done)
            g_d.busy = 1'b0;
        if (!g_q.pend && !g_q.busy && req) begin
            g_d.pend = 1'b1;
            g_d.lat  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign pend = g_q.pend;
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    localparam int IDW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]             pend,
    input  logic [NSRC-1:0]             en,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]           thr,
    output logic [IDW-1:0]              id,
    output logic                        hit
);
    // Strict compare against the running best: threshold is exclusive
    // and the lowest ID keeps a tie.
    always_comb begin
        logic [PRIO_W-1:0] best;
        best = thr;
        id   = '0;
        hit  = 1'b0;
        for (int i = 1; i < NSRC; i++) begin
            if (pend[i] && en[i] && (prio[i] > best)) begin
                best = prio[i];
                id   = IDW'(i);
                hit  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int NSRC   = 32,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCTX-1:0]   irq_o
);
    import irqc_pkg::*;

    localparam int IDW   = $clog2(NSRC);
    localparam int NWORD = (NSRC + 31) / 32;

    typedef struct packed {
        logic [NSRC-1:0][PRIO_W-1:0] prio;
        logic [NCTX-1:0][NSRC-1:0]   en;
        logic [NCTX-1:0][PRIO_W-1:0] thr;
        logic [NSRC-1:0]             trig;
        logic [NCTX-1:0]             irq;
        logic [31:0]                 rdata;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0]          pend;
    logic [NSRC-1:0]          take;
    logic [NSRC-1:0]          done;
    logic [NCTX-1:0][IDW-1:0] pick_id;
    logic [NCTX-1:0]          pick_hit;
    logic [NCTX-1:0][PRIO_W-1:0] thr_q;

    assign thr_q = st_q.thr;

    // One gateway per real source; ID 0 has none.
    assign pend[0] = 1'b0;
    for (genvar s = 1; s < NSRC; s++) begin : g_gate
        irqc_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .line      (src_i[s]),
            .edge_mode (st_q.trig[s]),
            .take      (take[s]),
            .done      (done[s]),
            .pend      (pend[s])
        );
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        irqc_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_pick (
            .pend (pend),
            .en   (st_q.en[c]),
            .prio (st_q.prio),
            .thr  (st_q.thr[c]),
            .id   (pick_id[c]),
            .hit  (pick_hit[c])
        );
    end

    always_comb begin
        logic [31:0] a;
        logic [31:0] off;
        logic [31:0] rd;
        int          c;
        int          w;
        int          s;
        st_d = st_q;
        take = '0;
        done = '0;
        rd   = '0;
        a    = 32'(bus_addr);
        off  = '0;
        c    = 0;
        w    = 0;
        s    = 0;
        if (bus_req) begin
            if (a >= BASE_CTL) begin
                off = a - BASE_CTL;
                c   = int'(off >> CTL_SHIFT);
                if (c < NCTX) begin
                    if (off[11:0] == OFF_THR) begin
                        if (bus_we) st_d.thr[c] = bus_wdata[PRIO_W-1:0];
                        rd = 32'(st_q.thr[c]);
                    end else if (off[11:0] == OFF_CLAIM) begin
                        if (bus_we) begin
                            if (bus_wdata != 32'd0 && bus_wdata < 32'(NSRC)
                                && st_q.en[c][bus_wdata[IDW-1:0]])
                                done[bus_wdata[IDW-1:0]] = 1'b1;
                        end else begin
                            rd = 32'(pick_id[c]);
                            if (pick_hit[c]) take[pick_id[c]] = 1'b1;
                        end
                    end
                end
            end else if (a >= BASE_EN) begin
                off = a - BASE_EN;
                c   = int'(off >> EN_SHIFT);
                w   = int'(off[EN_SHIFT-1:2]);
                if (c < NCTX && w < NWORD) begin
                    for (int b = 0; b < 32; b++) begin
                        s = w * 32 + b;
                        if (s < NSRC && s != 0) begin
                            if (bus_we) st_d.en[c][s] = bus_wdata[b];
                            rd[b] = st_q.en[c][s];
                        end
                    end
                end
            end else if (a >= BASE_TRIG) begin
                off = a - BASE_TRIG;
                w   = int'(off[11:2]);
                if (w < NWORD) begin
                    for (int b = 0; b < 32; b++) begin
                        s = w * 32 + b;
                        if (s < NSRC && s != 0) begin
                            if (bus_we) st_d.trig[s] = bus_wdata[b];
                            rd[b] = st_q.trig[s];
                        end
                    end
                end
            end else begin
                s = int'(a[11:2]);
                if (s < NSRC && s != 0) begin
                    if (bus_we) st_d.prio[s] = bus_wdata[PRIO_W-1:0];
                    rd = 32'(st_q.prio[s]);
                end
            end
            if (!bus_we) st_d.rdata = rd;
        end
        st_d.irq = pick_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq_o     = st_q.irq;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NSRC   = 32,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NSRC-1:0]             pend,
    input logic [NSRC-1:0]             take,
    input logic [NCTX-1:0][PRIO_W-1:0] thr_q,
    input logic [NCTX-1:0]             irq_o,
    input logic [31:0]                 bus_rdata
);
    // R6: one claim takes at most one source
    p_one_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));

    // R6: a claimed source is no longer pending afterwards
    p_claim_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|take) |=> ((pend & $past(take)) == '0));

    // R1/R11: a successful claim never hands out ID 0
    p_claim_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|take) |=> (bus_rdata != 32'd0));

    // R7: a pending source stays pending until it is claimed
    p_pend_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |=> ((pend | take) == (pend | take | ($past(pend) & ~$past(take))))
        or ((($past(pend) & ~$past(take)) & ~pend) == '0));

    // R5: a maximum threshold blocks the context's request
    for (genvar c = 0; c < NCTX; c++) begin : g_thr
        p_thr_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_q[c] == {PRIO_W{1'b1}}) |=> !irq_o[c]);
    end
endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .take      (take),
    .thr_q     (thr_q),
    .irq_o     (irq_o),
    .bus_rdata (bus_rdata)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    localparam int NSRC   = 32;
    localparam int NCTX   = 2;
    localparam int PRIO_W = 3;
    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_i = '0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCTX-1:0]   irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    irqc_top #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [ADDR_W-1:0] a_prio(int i);
        return ADDR_W'(4 * i);
    endfunction
    function automatic logic [ADDR_W-1:0] a_en(int c);
        return ADDR_W'(32'h2000 + 32'h80 * c);
    endfunction
    function automatic logic [ADDR_W-1:0] a_thr(int c);
        return ADDR_W'(32'h200000 + 32'h1000 * c);
    endfunction
    function automatic logic [ADDR_W-1:0] a_clm(int c);
        return ADDR_W'(32'h200004 + 32'h1000 * c);
    endfunction
    localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(32'h1000);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bw(logic [ADDR_W-1:0] a, logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic br(logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        src_i = '0;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R10 reset irq", 32'(irq_o), 32'd0);
        br(a_clm(0), d);
        chk("R1 empty claim", d, 32'd0);
        br(a_prio(3), d);
        chk("R2 reset prio", d, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        do_reset();
        bw(a_prio(5), 32'd6);
        br(a_prio(5), d);
        chk("R2 prio readback", d, 32'd6);
        bw(a_prio(6), 32'hFF);
        br(a_prio(6), d);
        chk("R2 prio width", d, 32'd7);
        bw(a_prio(0), 32'd5);
        br(a_prio(0), d);
        chk("R1 prio0", d, 32'd0);
        bw(a_en(1), 32'hFFFF_FFFF);
        br(a_en(1), d);
        chk("R3 enable bit0", d, 32'hFFFF_FFFE);
        br(a_en(0), d);
        chk("R3 ctx0 separate", d, 32'd0);
        bw(A_TRIG, 32'h0000_0081);
        br(A_TRIG, d);
        chk("R4 trig map", d, 32'h0000_0080);
        bw(a_thr(1), 32'd5);
        br(a_thr(1), d);
        chk("R4 thr map", d, 32'd5);
        tick(3);
        chk("R11 rdata held", bus_rdata, 32'd5);
    endtask

    task automatic t_threshold();
        do_reset();
        bw(a_prio(3), 32'd2);
        bw(a_thr(0), 32'd2);
        bw(a_en(0), 32'h8);
        src_i[3] = 1'b1;
        tick(2);
        chk("R5 equal blocks", 32'(irq_o), 32'd0);
        bw(a_thr(0), 32'd1);
        tick(1);
        chk("R10 write to irq", 32'(irq_o[0]), 32'd1);
        bw(a_thr(0), 32'd7);
        tick(1);
        chk("R5 thr max", 32'(irq_o[0]), 32'd0);
        bw(a_thr(0), 32'd0);
        bw(a_prio(3), 32'd0);
        tick(1);
        chk("R5 prio zero", 32'(irq_o[0]), 32'd0);
        do_reset();
        bw(a_prio(3), 32'd1);
        bw(a_en(0), 32'h8);
        tick(1);
        src_i[3] = 1'b1;
        tick(1);
        chk("R10 not combinational", 32'(irq_o[0]), 32'd0);
        tick(1);
        chk("R10 line to irq", 32'(irq_o[0]), 32'd1);
    endtask

    task automatic t_arb();
        logic [31:0] d;
        do_reset();
        bw(a_prio(4), 32'd3);
        bw(a_prio(9), 32'd5);
        bw(a_prio(12), 32'd5);
        bw(a_en(0), 32'h1210);
        src_i[4] = 1'b1; src_i[9] = 1'b1; src_i[12] = 1'b1;
        tick(2);
        br(a_clm(0), d); chk("R6 highest", d, 32'd9);
        br(a_clm(0), d); chk("R6 tie low id", d, 32'd12);
        br(a_clm(0), d); chk("R6 lower prio", d, 32'd4);
        br(a_clm(0), d); chk("R6 all taken", d, 32'd0);
        bw(a_clm(0), 32'd9);
        tick(1);
        br(a_clm(0), d); chk("R8 level re-pend", d, 32'd9);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        do_reset();
        bw(A_TRIG, 32'h80);
        bw(a_prio(7), 32'd4);
        bw(a_en(0), 32'h80);
        src_i[7] = 1'b1;
        tick(1);
        src_i[7] = 1'b0;
        tick(1);
        chk("R9 pulse irq", 32'(irq_o[0]), 32'd1);
        br(a_clm(0), d); chk("R9 pulse claim", d, 32'd7);
        src_i[7] = 1'b1;
        tick(1);
        br(a_clm(0), d); chk("R7 in service", d, 32'd0);
        bw(a_clm(0), 32'd7);
        tick(1);
        br(a_clm(0), d); chk("R9 held edge", d, 32'd7);
        bw(a_clm(0), 32'd7);
        tick(1);
        br(a_clm(0), d); chk("R9 steady high", d, 32'd0);
    endtask

    task automatic t_complete();
        logic [31:0] d;
        do_reset();
        bw(a_prio(3), 32'd1);
        bw(a_en(0), 32'h8);
        src_i[3] = 1'b1;
        tick(2);
        br(a_clm(0), d); chk("R6 claim", d, 32'd3);
        bw(a_clm(1), 32'd3);
        tick(1);
        br(a_clm(0), d); chk("R7 wrong ctx ignored", d, 32'd0);
        bw(a_clm(0), 32'd40);
        tick(1);
        br(a_clm(0), d); chk("R7 range ignored", d, 32'd0);
        bw(a_clm(0), 32'd3);
        tick(1);
        br(a_clm(0), d); chk("R7 retire", d, 32'd3);
    endtask

    task automatic t_ctx();
        logic [31:0] d;
        do_reset();
        bw(a_prio(10), 32'd1);
        bw(a_en(1), 32'h400);
        src_i[10] = 1'b1;
        tick(2);
        chk("R12 only ctx1", 32'(irq_o), 32'd2);
        br(a_clm(0), d); chk("R12 ctx0 empty", d, 32'd0);
        br(a_clm(1), d); chk("R12 ctx1 claim", d, 32'd10);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regs();
        t_threshold();
        t_arb();
        t_edge();
        t_complete();
        t_ctx();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule